// File: doc/BRIEF.md
# Interrupt Destination Mask Decoder

This block turns an interrupt request's addressing fields into the set of agents that should receive it. A request carries an 8-bit destination, a bit choosing physical or logical addressing, a 2-bit shorthand and the index of the sending agent. An internal table holds one entry per agent. Each entry has a present flag, an 8-bit physical ID, an 8-bit logical ID and a 4-bit logical model. The table is loaded through a simple write port.

One clock after a request strobe, the block presents a one-hot-per-agent target mask with a valid pulse. It also presents the single agent chosen for lowest-priority delivery, which is the lowest-indexed agent in the mask. A flag says whether any agent was chosen. Delivering the interrupt and comparing arbitration priorities are left to the surrounding logic.

Top module: `irq_dest_decoder`

## Requirements
- R1: While reset is asserted and after its release, until the first request, out_valid, out_mask, out_lp_found and out_lp_idx are all zero.
- R2: A request sampled with req_valid high at a rising edge gives out_valid high for exactly the following cycle. The mask and lowest-priority outputs update at that same edge and hold their values while no request is made.
- R3: With shorthand 2'b00 and physical addressing (req_logical = 0), a destination of 8'hFF selects every present agent.
- R4: With shorthand 2'b00, physical addressing and any other destination, every present agent whose physical ID equals the destination is selected.
- R5: With shorthand 2'b00 and logical addressing, an agent whose model is 4'hF (flat) matches when the destination AND its logical ID is non-zero.
- R6: With logical addressing, an agent whose model is 4'h0 (cluster) matches when bits 7:4 of the destination and of its logical ID are equal and bits 3:0 of both share a set bit. An agent with any other model value never matches in logical addressing.
- R7: In logical addressing, agent i can match only if agents 0 through i are all present. The first absent entry ends the search.
- R8: Shorthand 2'b01 selects only the sender. Shorthand 2'b10 selects all present agents, including the sender. Shorthand 2'b11 selects all present agents except the sender. The destination and mode inputs are ignored for these three shorthands.
- R9: An agent whose table entry is not present never appears in out_mask.
- R10: out_lp_idx is the lowest index set in out_mask, and out_lp_found is high. When the mask is empty, out_lp_found is 0 and out_lp_idx is 0.
- R11: With tbl_we high at a rising edge, the entry at tbl_idx is replaced by the write data. A request sampled at the same edge is decoded against the table contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write enable |
| tbl_idx | input | IDX_W | Table entry to write |
| tbl_present | input | 1 | Present flag write data |
| tbl_phys_id | input | 8 | Physical ID write data |
| tbl_log_id | input | 8 | Logical ID write data |
| tbl_model | input | 4 | Logical model write data |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 8 | Destination field |
| req_logical | input | 1 | 1 = logical addressing, 0 = physical |
| req_short | input | 2 | Shorthand (00 fields, 01 self, 10 all, 11 all but self) |
| req_self | input | IDX_W | Index of the sending agent |
| out_valid | output | 1 | Result valid pulse |
| out_mask | output | N_AGENTS | Target mask, bit i = agent i |
| out_lp_found | output | 1 | A lowest-priority target exists |
| out_lp_idx | output | IDX_W | Lowest-priority target index |

## Verification
The bench sweeps all 256 destinations in both addressing modes against three table setups:
- an all-flat table with two agents sharing a physical ID;
- a table mixing cluster and flat entries, with one unknown model and an absent last agent;
- a table with a gap at agent 2.

A decoder that treated 8'hFF as an ordinary ID would miss the broadcast. One that returned only the first physical match would drop the duplicate. One that compared the whole cluster byte instead of splitting it into nibbles would miss partial cluster hits. One that skipped over an absent entry instead of stopping would select agents beyond the gap.

The three shorthands are swept over every sender index; a swapped self and all-but-self encoding shows up at once. A table write that coincides with a request catches a decoder that reads the table combinationally after the write. Empty masks check that the lowest-priority pick does not claim a target.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

  localparam int ID_W    = 8;
  localparam int MODEL_W = 4;

  localparam logic [ID_W-1:0]    BCAST_ID      = 8'hFF;
  localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
  localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;

  typedef enum logic [1:0] {
    SH_FIELDS = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } shorthand_e;

  typedef struct packed {
    logic               present;
    logic [ID_W-1:0]    phys_id;
    logic [ID_W-1:0]    log_id;
    logic [MODEL_W-1:0] model;
  } agent_t;

endpackage

// File: rtl/irq_dest_table.sv
module irq_dest_table #(
  parameter int N_AGENTS = 8,
  parameter int IDX_W    = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we_i,
  input  logic [IDX_W-1:0]                    widx_i,
  input  irq_dest_pkg::agent_t                wdata_i,
  output irq_dest_pkg::agent_t [N_AGENTS-1:0] entries_o
);

  logic [N_AGENTS-1:0] wr_hit;

  for (genvar i = 0; i < N_AGENTS; i++) begin : g_entry
    // write decode: one enable per entry
    always_comb begin
      wr_hit[i] = we_i && (widx_i == IDX_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entries_o[i] <= '0;
      end else if (wr_hit[i]) begin
        entries_o[i] <= wdata_i;
      end
    end
  end

endmodule

// File: rtl/irq_dest_match.sv
module irq_dest_match #(
  parameter int N_AGENTS = 8,
  parameter int IDX_W    = 3
) (
  input  irq_dest_pkg::agent_t [N_AGENTS-1:0] entries_i,
  input  logic [irq_dest_pkg::ID_W-1:0]       dest_i,
  input  logic                                logical_i,
  input  irq_dest_pkg::shorthand_e            short_i,
  input  logic [IDX_W-1:0]                    self_i,
  output logic [N_AGENTS-1:0]                 mask_o
);
  import irq_dest_pkg::*;

  localparam int NIB = ID_W / 2;

  logic [N_AGENTS-1:0] present;
  logic [N_AGENTS-1:0] chain_ok;
  logic [N_AGENTS-1:0] phys_hit;
  logic [N_AGENTS-1:0] log_hit;
  logic [N_AGENTS-1:0] self_oh;
  logic                is_bcast;

  for (genvar i = 0; i < N_AGENTS; i++) begin : g_agent
    logic flat_hit;
    logic clus_hit;

    assign present[i] = entries_i[i].present;

    // logical search ends at the first absent entry
    if (i == 0) begin : g_first
      assign chain_ok[i] = present[i];
    end else begin : g_rest
      assign chain_ok[i] = chain_ok[i-1] & present[i];
    end

    assign phys_hit[i] = present[i] && (entries_i[i].phys_id == dest_i);

    assign flat_hit = (entries_i[i].model == MODEL_FLAT) &&
                      (|(dest_i & entries_i[i].log_id));

    assign clus_hit = (entries_i[i].model == MODEL_CLUSTER) &&
                      (dest_i[ID_W-1:NIB] == entries_i[i].log_id[ID_W-1:NIB]) &&
                      (|(dest_i[NIB-1:0] & entries_i[i].log_id[NIB-1:0]));

    assign log_hit[i] = chain_ok[i] && (flat_hit || clus_hit);
  end

  assign self_oh  = N_AGENTS'(1) << self_i;
  assign is_bcast = (dest_i == BCAST_ID);

  always_comb begin
    unique case (short_i)
      SH_SELF:   mask_o = present & self_oh;
      SH_ALL:    mask_o = present;
      SH_OTHERS: mask_o = present & ~self_oh;
      default: begin
        if (logical_i) begin
          mask_o = log_hit;
        end else if (is_bcast) begin
          mask_o = present;
        end else begin
          mask_o = phys_hit;
        end
      end
    endcase
  end

endmodule

// File: rtl/irq_dest_lowest.sv
module irq_dest_lowest #(
  parameter int N_AGENTS = 8,
  parameter int IDX_W    = 3
) (
  input  logic [N_AGENTS-1:0] mask_i,
  output logic                found_o,
  output logic [IDX_W-1:0]    idx_o
);

  always_comb begin
    found_o = |mask_i;
    idx_o   = '0;
    for (int i = N_AGENTS - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_dest_decoder.sv
module irq_dest_decoder #(
  parameter int N_AGENTS = 8,
  localparam int IDX_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tbl_we,
  input  logic [IDX_W-1:0]    tbl_idx,
  input  logic                tbl_present,
  input  logic [7:0]          tbl_phys_id,
  input  logic [7:0]          tbl_log_id,
  input  logic [3:0]          tbl_model,
  input  logic                req_valid,
  input  logic [7:0]          req_dest,
  input  logic                req_logical,
  input  logic [1:0]          req_short,
  input  logic [IDX_W-1:0]    req_self,
  output logic                out_valid,
  output logic [N_AGENTS-1:0] out_mask,
  output logic                out_lp_found,
  output logic [IDX_W-1:0]    out_lp_idx
);
  import irq_dest_pkg::*;

  agent_t [N_AGENTS-1:0] tbl_q;
  agent_t                wdata;
  logic [N_AGENTS-1:0]   present_vec;
  logic [N_AGENTS-1:0]   mask_c;
  logic                  lp_found_c;
  logic [IDX_W-1:0]      lp_idx_c;

  logic                  valid_d;
  logic [N_AGENTS-1:0]   mask_d;
  logic                  lp_found_d;
  logic [IDX_W-1:0]      lp_idx_d;

  assign wdata = '{present: tbl_present, phys_id: tbl_phys_id,
                   log_id: tbl_log_id, model: tbl_model};

  irq_dest_table #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (tbl_we),
    .widx_i    (tbl_idx),
    .wdata_i   (wdata),
    .entries_o (tbl_q)
  );

  for (genvar i = 0; i < N_AGENTS; i++) begin : g_pres
    assign present_vec[i] = tbl_q[i].present;
  end

  irq_dest_match #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) u_match (
    .entries_i (tbl_q),
    .dest_i    (req_dest),
    .logical_i (req_logical),
    .short_i   (shorthand_e'(req_short)),
    .self_i    (req_self),
    .mask_o    (mask_c)
  );

  irq_dest_lowest #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) u_lowest (
    .mask_i  (mask_c),
    .found_o (lp_found_c),
    .idx_o   (lp_idx_c)
  );

  // next-state
  always_comb begin
    valid_d    = req_valid;
    mask_d     = out_mask;
    lp_found_d = out_lp_found;
    lp_idx_d   = out_lp_idx;
    if (req_valid) begin
      mask_d     = mask_c;
      lp_found_d = lp_found_c;
      lp_idx_d   = lp_idx_c;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_mask     <= '0;
      out_lp_found <= 1'b0;
      out_lp_idx   <= '0;
    end else begin
      out_valid <= valid_d;
      if (req_valid) begin
        out_mask     <= mask_d;
        out_lp_found <= lp_found_d;
        out_lp_idx   <= lp_idx_d;
      end
    end
  end

endmodule

// File: rtl/irq_dest_chk.sv
module irq_dest_chk #(
  parameter int N_AGENTS = 8,
  parameter int IDX_W    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [1:0]          req_short,
  input logic [IDX_W-1:0]    req_self,
  input logic [N_AGENTS-1:0] present_vec,
  input logic                out_valid,
  input logic [N_AGENTS-1:0] out_mask,
  input logic                out_lp_found,
  input logic [IDX_W-1:0]    out_lp_idx
);

  logic [N_AGENTS-1:0] below_lp;
  assign below_lp = (N_AGENTS'(1) << out_lp_idx) - N_AGENTS'(1);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(out_mask) && $stable(out_lp_found) && $stable(out_lp_idx)));

  // R9
  absent_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ((out_mask & ~$past(present_vec)) == '0));

  // R10
  lp_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_lp_found == (|out_mask)));

  // R10
  lp_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_lp_found |-> out_mask[out_lp_idx]);

  // R10
  lp_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_lp_found |-> ((out_mask & below_lp) == '0));

  // R8
  self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_short == 2'b01) |=> ($countones(out_mask) <= 1));

  // R8
  others_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_short == 2'b11) |=> !out_mask[$past(req_self)]);

endmodule

bind irq_dest_decoder irq_dest_chk #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_short    (req_short),
  .req_self     (req_self),
  .present_vec  (present_vec),
  .out_valid    (out_valid),
  .out_mask     (out_mask),
  .out_lp_found (out_lp_found),
  .out_lp_idx   (out_lp_idx)
);

// File: tb/test_irq_dest_decoder.sv
module test_irq_dest_decoder;

  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tbl_we;
  logic [IW-1:0] tbl_idx;
  logic          tbl_present;
  logic [7:0]    tbl_phys_id;
  logic [7:0]    tbl_log_id;
  logic [3:0]    tbl_model;
  logic          req_valid;
  logic [7:0]    req_dest;
  logic          req_logical;
  logic [1:0]    req_short;
  logic [IW-1:0] req_self;
  logic          out_valid;
  logic [N-1:0]  out_mask;
  logic          out_lp_found;
  logic [IW-1:0] out_lp_idx;

  always #4 clk = ~clk;

  irq_dest_decoder #(.N_AGENTS(N)) i_irq_dest_decoder (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_present(tbl_present),
    .tbl_phys_id(tbl_phys_id), .tbl_log_id(tbl_log_id), .tbl_model(tbl_model),
    .req_valid(req_valid), .req_dest(req_dest), .req_logical(req_logical),
    .req_short(req_short), .req_self(req_self),
    .out_valid(out_valid), .out_mask(out_mask),
    .out_lp_found(out_lp_found), .out_lp_idx(out_lp_idx)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic       bpres [N];
  logic [7:0] bphys [N];
  logic [7:0] blog  [N];
  logic [3:0] bmod  [N];

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] pres_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = bpres[i];
    return v;
  endfunction

  function automatic logic [N-1:0] exp_mask(input logic [7:0] d, input logic lg,
                                            input logic [1:0] sh, input int s);
    logic [N-1:0] m;
    logic [N-1:0] pv;
    logic         run;
    pv = pres_vec();
    m  = '0;
    case (sh)
      2'd1: m[s] = bpres[s];
      2'd2: m = pv;
      2'd3: begin m = pv; m[s] = 1'b0; end
      default: begin
        if (!lg) begin
          if (d == 8'hFF) m = pv;
          else for (int i = 0; i < N; i++) m[i] = bpres[i] && (bphys[i] == d);
        end else begin
          run = 1'b1;
          for (int i = 0; i < N; i++) begin
            run = run && bpres[i];
            if (run) begin
              if (bmod[i] == 4'hF)
                m[i] = (d & blog[i]) != 8'h00;
              else if (bmod[i] == 4'h0)
                m[i] = (d[7:4] == blog[i][7:4]) && ((d[3:0] & blog[i][3:0]) != 4'h0);
            end
          end
        end
      end
    endcase
    return m;
  endfunction

  task automatic wr_agent(input int i, input logic p, input logic [7:0] ph,
                          input logic [7:0] lg, input logic [3:0] md);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = IW'(i); tbl_present = p;
    tbl_phys_id = ph; tbl_log_id = lg; tbl_model = md;
    @(negedge clk);
    tbl_we = 1'b0;
    bpres[i] = p; bphys[i] = ph; blog[i] = lg; bmod[i] = md;
  endtask

  task automatic check_result(input string tag, input logic [N-1:0] em);
    logic       ef;
    logic [IW-1:0] ei;
    ef = |em;
    ei = '0;
    for (int i = N - 1; i >= 0; i--) if (em[i]) ei = IW'(i);
    chk("R2", "out_valid", 32'(out_valid), 32'd1);
    chk(tag, "out_mask", 32'(out_mask), 32'(em));
    chk("R9", "absent bits", 32'(out_mask & ~pres_vec()), 32'd0);
    chk("R10", "lp_found", 32'(out_lp_found), 32'(ef));
    chk("R10", "lp_idx", 32'(out_lp_idx), 32'(ei));
  endtask

  task automatic do_req(input logic [7:0] d, input logic lg, input logic [1:0] sh,
                        input int s, input string tag);
    logic [N-1:0] em;
    @(negedge clk);
    req_valid = 1'b1; req_dest = d; req_logical = lg; req_short = sh; req_self = IW'(s);
    em = exp_mask(d, lg, sh, s);
    @(negedge clk);
    req_valid = 1'b0;
    check_result(tag, em);
  endtask

  task automatic idle_chk();
    logic [N-1:0] prev;
    prev = out_mask;
    @(negedge clk);
    chk("R2", "out_valid idle", 32'(out_valid), 32'd0);
    chk("R2", "mask hold", 32'(out_mask), 32'(prev));
  endtask

  task automatic sweep(input string ltag);
    for (int d = 0; d < 256; d++) begin
      do_req(8'(d), 1'b0, 2'b00, d % N, (d == 255) ? "R3" : "R4");
      do_req(8'(d), 1'b1, 2'b00, d % N, ltag);
    end
    idle_chk();
    for (int sh = 1; sh < 4; sh++)
      for (int s = 0; s < N; s++) begin
        do_req(8'h5A, 1'b1, 2'(sh), s, "R8");
        do_req(8'hFF, 1'b0, 2'(sh), s, "R8");
      end
    idle_chk();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    tbl_we = 1'b0; tbl_idx = '0; tbl_present = 1'b0;
    tbl_phys_id = '0; tbl_log_id = '0; tbl_model = '0;
    req_valid = 1'b0; req_dest = '0; req_logical = 1'b0; req_short = '0; req_self = '0;
    for (int i = 0; i < N; i++) begin
      bpres[i] = 1'b0; bphys[i] = '0; blog[i] = '0; bmod[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "out_valid", 32'(out_valid), 32'd0);
    chk("R1", "out_mask", 32'(out_mask), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 after release
    chk("R1", "out_valid", 32'(out_valid), 32'd0);
    chk("R1", "out_mask", 32'(out_mask), 32'd0);
    chk("R1", "lp_found", 32'(out_lp_found), 32'd0);
    chk("R1", "lp_idx", 32'(out_lp_idx), 32'd0);

    // empty table: nothing selected (R9, R10)
    do_req(8'hFF, 1'b0, 2'b10, 0, "R9");

    // config A: all flat, agents 2 and 6 share a physical ID (R5)
    for (int i = 0; i < N; i++)
      wr_agent(i, 1'b1, (i == 6) ? 8'h22 : 8'(8'h20 + i), 8'(1 << i), 4'hF);
    sweep("R5");

    // R11: write agent 0 absent in the same cycle as a request for it
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = '0; tbl_present = 1'b0;
    tbl_phys_id = 8'h20; tbl_log_id = 8'h01; tbl_model = 4'hF;
    req_valid = 1'b1; req_dest = 8'h20; req_logical = 1'b0; req_short = 2'b00; req_self = '0;
    @(negedge clk);
    tbl_we = 1'b0; req_valid = 1'b0;
    chk("R11", "same-cycle old table", 32'(out_mask), 32'h01);
    bpres[0] = 1'b0;
    do_req(8'h20, 1'b0, 2'b00, 0, "R11");
    do_req(8'h01, 1'b1, 2'b00, 0, "R11");

    // config B: cluster/flat mix, one unknown model, last agent absent (R6)
    for (int i = 0; i < N; i++) begin
      if (i == 7)      wr_agent(i, 1'b0, 8'h37, 8'hFF, 4'hF);
      else if (i == 5) wr_agent(i, 1'b1, 8'h35, 8'hFF, 4'h3);
      else if (i % 2 == 0)
        wr_agent(i, 1'b1, 8'(8'h30 + i), {4'(i / 2 + 1), 4'(1 << (i % 4))}, 4'h0);
      else
        wr_agent(i, 1'b1, 8'(8'h30 + i), 8'(8'h11 << (i % 4)), 4'hF);
    end
    sweep("R6");

    // config C: gap at agent 2 ends the logical search (R7)
    for (int i = 0; i < N; i++)
      wr_agent(i, (i != 2), 8'(8'h40 + i), 8'hFF, 4'hF);
    sweep("R7");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule